// File: doc/BRIEF.md
# Sampling Phase Tuning Engine

The engine picks a receive sampling phase for a card interface whose receive clock can be sampled at one of eight phase positions. A start pulse launches a sweep that begins at the currently programmed phase, advances the phase by one before each trial, and runs one tuning transfer per phase through a request/response handshake with an external tuning-command port. The port answers each trial with pass or fail. The engine records the answers in an eight-bit pass map.

After the sweep, a scanner searches the pass map for the centre of a run of passing phases. It rotates the map right by 0 to 7 and compares each rotation first against a wide window mask and then against a narrower fallback mask. The first match sets the new phase and is saved as the tuned value. If nothing matches, the engine raises an error and keeps the previous tuned value. A later high-speed mode switch can copy the saved tuned value back into the phase field.

Top module: `phase_tune_engine`

## Requirements
- R1: The phase is a 3-bit value with eight positions. A sweep captures the current phase as its start point and adds one (mod 8) to the phase before each trial. After the trial at the start phase it stops, so it makes exactly eight trials, in the order start+1, start+2, …, start.
- R2: Each trial asserts `trial_req_o` for exactly one cycle, with `trial_phase_o` equal to the phase under test. No further request is issued until `trial_done_i` has been seen. `trial_pass_i` is sampled only together with `trial_done_i`.
- R3: `data_tmo_o` is all ones whenever `trial_req_o` is high. It is zero after reset.
- R4: The pass map is cleared when a sweep starts. A trial that passes sets map bit n, where n is the phase that trial tested.
- R5: Wide pass: for i = 0..7 in increasing order, the first i for which (map rotated right by i) AND 0xC7 equals 0xC7 is selected.
- R6: Fallback pass: only if no rotation matches 0xC7, the same ascending scan is done with mask 0x83, and the first match is selected.
- R7: If neither mask matches, `err_o` is set, `tuned_o` keeps its previous value, and the phase is left at the sweep's start value.
- R8: On a match, the phase and `tuned_o` both take the selected index and `err_o` is cleared.
- R9: `done_o` is a one-cycle pulse. It comes k+1 clock edges after the edge that samples the final `trial_done_i`, where k (0..15) is the scan step that decided: wide rotation i gives k = i, fallback rotation i gives k = 8+i, and no match gives k = 15. `busy_o` is high from the accepted start through the done cycle.
- R10: A start pulse that arrives while `busy_o` is high is ignored. The running sweep neither restarts nor lengthens.
- R11: While idle, `phase_load_i` writes `phase_val_i` into the phase, and `tuned_reload_i` (without a load) copies `tuned_o` into the phase. Both are ignored while busy.
- R12: After reset the engine is idle, and `phase_o`, `tuned_o` and `err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a tuning sweep (ignored while busy) |
| phase_load_i | input | 1 | Write `phase_val_i` into the phase field when idle |
| phase_val_i | input | 3 | Phase value to write |
| tuned_reload_i | input | 1 | Copy the tuned value into the phase field when idle (mode switch) |
| trial_done_i | input | 1 | Tuning-command port has finished the current trial |
| trial_pass_i | input | 1 | Result of the trial, valid with `trial_done_i` |
| trial_req_o | output | 1 | One-cycle request for a tuning trial |
| trial_phase_o | output | 3 | Phase under test |
| data_tmo_o | output | TMO_W | Data timeout setting, forced to all ones before each trial |
| phase_o | output | 3 | Programmed sampling phase |
| tuned_o | output | 3 | Saved tuned sample |
| busy_o | output | 1 | Sweep or selection in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last sweep found no usable window |

## Verification
The hardest outcomes to reach are the narrow fallback match and the no-match error. Both depend on the complete pass pattern across all eight trials, and on the sweep's start phase, which rotates the order of the trials. The bench therefore drives every one of the 256 pass maps, choosing each map's start phase and response latency from its index. The pass result for each trial is looked up from the phase the engine actually requested. This reaches every wide, fallback and error path, and it also lets the bench predict the exact cycle of `done_o`. Extra start pulses injected in the middle of sweeps, together with loads and reloads after each sweep, exercise the rules for ignored and mode-switch inputs.

// File: rtl/ptune_pkg.sv
package ptune_pkg;
  localparam int unsigned PH_W = 3;
  localparam int unsigned NPH  = 1 << PH_W;
  localparam int unsigned SCAN_W = PH_W + 1;
  localparam logic [NPH-1:0] WIDE_MASK   = 8'hC7;
  localparam logic [NPH-1:0] NARROW_MASK = 8'h83;

  typedef enum logic [2:0] {
    S_IDLE, S_ADV, S_REQ, S_WAIT, S_SCAN, S_FIN
  } sweep_state_e;

  function automatic logic [NPH-1:0] ror_map(logic [NPH-1:0] v, logic [PH_W-1:0] n);
    logic [NPH-1:0] r;
    for (int b = 0; b < NPH; b++) r[b] = v[PH_W'(b) + n];
    return r;
  endfunction

  function automatic logic any_hit(logic [NPH-1:0] v, logic [NPH-1:0] m);
    logic h;
    h = 1'b0;
    for (int i = 0; i < NPH; i++)
      if ((ror_map(v, PH_W'(i)) & m) == m) h = 1'b1;
    return h;
  endfunction
endpackage

// File: rtl/ptune_sweep.sv
module ptune_sweep
  import ptune_pkg::*;
#(
  parameter int unsigned TMO_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            trial_done_i,
  input  logic            trial_pass_i,
  input  logic            scan_res_i,
  output logic            accept_o,
  output logic            adv_o,
  output logic            trial_req_o,
  output logic            scan_go_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [NPH-1:0]  map_o,
  output logic [TMO_W-1:0] tmo_o
);
  sweep_state_e    state_q;
  logic [PH_W-1:0] start_ph_q;
  logic            last_trial;

  assign accept_o    = (state_q == S_IDLE) && start_i;
  assign adv_o       = (state_q == S_ADV);
  assign trial_req_o = (state_q == S_REQ);
  assign last_trial  = (state_q == S_WAIT) && trial_done_i && (phase_i == start_ph_q);
  assign scan_go_o   = last_trial;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      start_ph_q <= '0;
      map_o      <= '0;
      tmo_o      <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          start_ph_q <= phase_i;
          map_o      <= '0;
          state_q    <= S_ADV;
        end
        S_ADV: begin
          tmo_o   <= '1;
          state_q <= S_REQ;
        end
        S_REQ: state_q <= S_WAIT;
        S_WAIT: if (trial_done_i) begin
          if (trial_pass_i) map_o[phase_i] <= 1'b1;
          state_q <= last_trial ? S_SCAN : S_ADV;
        end
        S_SCAN: if (scan_res_i) state_q <= S_FIN;
        S_FIN:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r2_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trial_req_o |=> !trial_req_o);
  a_r2_no_req_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !trial_done_i) |=> !trial_req_o);
  a_r3_tmo_at_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trial_req_o |-> (&tmo_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_busy_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/ptune_select.sv
module ptune_select
  import ptune_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [NPH-1:0]  map_i,
  output logic            res_valid_o,
  output logic            found_o,
  output logic [PH_W-1:0] sel_o
);
  localparam logic [SCAN_W-1:0] LAST_STEP = SCAN_W'(2 * NPH - 1);

  logic              run_q;
  logic [SCAN_W-1:0] cnt_q;
  logic [NPH-1:0]    rot, mask;
  logic              hit;

  always_comb begin
    rot  = ror_map(map_i, cnt_q[PH_W-1:0]);
    mask = cnt_q[PH_W] ? NARROW_MASK : WIDE_MASK;
    hit  = (rot & mask) == mask;
  end

  assign res_valid_o = run_q && (hit || cnt_q == LAST_STEP);
  assign found_o     = run_q && hit;
  assign sel_o       = cnt_q[PH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (go_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (res_valid_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // fallback hit only when no wide window exists anywhere
  a_r6_fallback_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && cnt_q[PH_W]) |-> !any_hit(map_i, WIDE_MASK));
  a_r7_miss_is_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !found_o) |-> !any_hit(map_i, NARROW_MASK));
  a_r9_res_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

// File: rtl/ptune_phase_reg.sv
module ptune_phase_reg
  import ptune_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            idle_i,
  input  logic            clr_err_i,
  input  logic            load_i,
  input  logic [PH_W-1:0] load_val_i,
  input  logic            reload_i,
  input  logic            adv_i,
  input  logic            res_valid_i,
  input  logic            found_i,
  input  logic [PH_W-1:0] sel_i,
  output logic [PH_W-1:0] phase_o,
  output logic [PH_W-1:0] tuned_o,
  output logic            err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      tuned_o <= '0;
      err_o   <= 1'b0;
    end else if (res_valid_i) begin
      if (found_i) begin
        phase_o <= sel_i;
        tuned_o <= sel_i;
        err_o   <= 1'b0;
      end else begin
        err_o   <= 1'b1;
      end
    end else if (adv_i) begin
      phase_o <= phase_o + 1'b1;
    end else if (idle_i) begin
      if (load_i)        phase_o <= load_val_i;
      else if (reload_i) phase_o <= tuned_o;
      if (clr_err_i)     err_o   <= 1'b0;
    end
  end

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> phase_o == $past(phase_o) + 1'b1);
  a_r7_keep_tuned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !found_i) |=> ($stable(tuned_o) && err_o));
  a_r8_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && found_i) |=> (phase_o == tuned_o && !err_o));
  a_r11_busy_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !adv_i && !res_valid_i) |=> $stable(phase_o));
endmodule

// File: rtl/phase_tune_engine.sv
module phase_tune_engine
  import ptune_pkg::*;
#(
  parameter int unsigned TMO_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             phase_load_i,
  input  logic [2:0]       phase_val_i,
  input  logic             tuned_reload_i,
  input  logic             trial_done_i,
  input  logic             trial_pass_i,
  output logic             trial_req_o,
  output logic [2:0]       trial_phase_o,
  output logic [TMO_W-1:0] data_tmo_o,
  output logic [2:0]       phase_o,
  output logic [2:0]       tuned_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic           accept, adv, scan_go, res_valid, found;
  logic [NPH-1:0] pass_map;
  logic [PH_W-1:0] sel;

  ptune_sweep #(.TMO_W(TMO_W)) u_sweep (
    .clk_i, .rst_ni, .start_i,
    .phase_i      (phase_o),
    .trial_done_i, .trial_pass_i,
    .scan_res_i   (res_valid),
    .accept_o     (accept),
    .adv_o        (adv),
    .trial_req_o,
    .scan_go_o    (scan_go),
    .busy_o, .done_o,
    .map_o        (pass_map),
    .tmo_o        (data_tmo_o)
  );

  ptune_select u_select (
    .clk_i, .rst_ni,
    .go_i        (scan_go),
    .map_i       (pass_map),
    .res_valid_o (res_valid),
    .found_o     (found),
    .sel_o       (sel)
  );

  ptune_phase_reg u_phase (
    .clk_i, .rst_ni,
    .idle_i      (!busy_o),
    .clr_err_i   (accept),
    .load_i      (phase_load_i),
    .load_val_i  (phase_val_i),
    .reload_i    (tuned_reload_i),
    .adv_i       (adv),
    .res_valid_i (res_valid),
    .found_i     (found),
    .sel_i       (sel),
    .phase_o, .tuned_o, .err_o
  );

  assign trial_phase_o = phase_o;

  a_r2_phase_under_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trial_req_o |-> trial_phase_o == $past(phase_o) + 1'b1);
  a_r8_done_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> phase_o == tuned_o);
endmodule

// File: tb/sim_phase_tune_engine.sv
module sim_phase_tune_engine;
  localparam int TMO_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ld = 1'b0, rl = 1'b0, tdone = 1'b0, tpass = 1'b0;
  logic [2:0] ld_val = '0;
  logic treq, busy, done, err;
  logic [2:0] tph, phase, tuned;
  logic [TMO_W-1:0] tmo;

  int checks = 0, fails = 0;
  logic [2:0] tuned_model = '0;

  always #10 clk = ~clk;

  phase_tune_engine #(.TMO_W(TMO_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .phase_load_i(ld), .phase_val_i(ld_val), .tuned_reload_i(rl),
    .trial_done_i(tdone), .trial_pass_i(tpass),
    .trial_req_o(treq), .trial_phase_o(tph), .data_tmo_o(tmo),
    .phase_o(phase), .tuned_o(tuned), .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rr(logic [7:0] v, int n);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = v[(b + n) % 8];
    return r;
  endfunction

  // returns decision step k; found when k<16 and a match existed
  task automatic pick(input logic [7:0] m, output logic f, output int sel, output int k);
    f = 1'b0; sel = 0; k = 15;
    for (int i = 0; i < 8; i++)
      if (!f && (rr(m, i) & 8'hC7) == 8'hC7) begin f = 1'b1; sel = i; k = i; end
    for (int i = 0; i < 8; i++)
      if (!f && (rr(m, i) & 8'h83) == 8'h83) begin f = 1'b1; sel = i; k = 8 + i; end
  endtask

  task automatic sweep(input int sp, input logic [7:0] m, input int lat, input logic poke);
    logic f; int sel, k, n, g;
    pick(m, f, sel, k);
    @(negedge clk); ld = 1'b1; ld_val = 3'(sp);
    @(negedge clk); ld = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy, "R9 busy after start", busy, 1);
    for (int t = 0; t < 8; t++) begin
      g = 0;
      while (!treq && g < 50) begin @(negedge clk); g++; end
      check(treq, "R2 request seen", treq, 1);
      check(tph == 3'((sp + t + 1) % 8), "R1 trial order", tph, (sp + t + 1) % 8);
      check(tmo == '1, "R3 timeout max", int'(tmo), int'({TMO_W{1'b1}}));
      begin
        int ph = tph;
        for (int d = 0; d <= lat; d++) begin
          @(negedge clk);
          check(!treq, "R2 no request while pending", treq, 0);
          if (poke && t == 3 && d == 0) start = 1'b1; else start = 1'b0;
        end
        start = 1'b0;
        tdone = 1'b1; tpass = m[ph];
      end
      if (t < 7) begin
        @(negedge clk); tdone = 1'b0; tpass = 1'b0;
      end
    end
    n = 0;
    do begin
      @(negedge clk); n++;
      tdone = 1'b0; tpass = 1'b0;
    end while (!done && n < 40);
    check(n == k + 2, "R9 done timing", n, k + 2);
    check(busy, "R9 busy during done", busy, 1);
    check(err == !f, f ? "R8 err clear" : "R7 err set", err, !f);
    if (f) begin
      tuned_model = 3'(sel);
      check(phase == 3'(sel), k < 8 ? "R5 wide phase" : "R6 fallback phase", phase, sel);
      check(tuned == 3'(sel), "R8 tuned saved", tuned, sel);
    end else begin
      check(phase == 3'(sp), "R7 phase at start", phase, sp);
      check(tuned == tuned_model, "R7 tuned kept", tuned, tuned_model);
    end
    @(negedge clk);
    check(!done && !busy, "R9 done single cycle", done, 0);
    check(!treq, "R10 no restart", treq, 0);
    ld = 1'b1; ld_val = 3'(sp + 3);
    @(negedge clk); ld = 1'b0; rl = 1'b1;
    check(phase == 3'(sp + 3), "R11 load", phase, (sp + 3) % 8);
    @(negedge clk); rl = 1'b0;
    check(phase == tuned_model, "R11 reload tuned", phase, tuned_model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phase == 0 && tuned == 0 && !err, "R12 reset regs", phase, 0);
    check(!busy && !done && !treq, "R12 reset idle", busy, 0);
    check(tmo == '0, "R3 timeout reset", int'(tmo), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 256; m++)
      sweep((m * 5 + m / 8) % 8, 8'(m), m % 3, (m % 4) == 1);
    // R4: map cleared between sweeps: all-pass then all-fail must error
    sweep(2, 8'hFF, 0, 1'b0);
    sweep(6, 8'h00, 1, 1'b0);
    check(err, "R4 map cleared", err, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule